// File: doc/BRIEF.md
# Timebase prescaler with input filter

This block produces the count-enable tick that advances a free-running timebase. The prescaler input is chosen by a two-bit source field. One choice is an asynchronous external clock pin. That pin is first brought into the system clock domain, then cleaned by a glitch filter. The other choice is a steady enable at half the system clock rate. The chosen source is divided by a programmable factor of one to 256. Each completed division raises a one-cycle tick and advances a timebase counter.

The filter samples the synchronized pin on one of two sample enables. One is every second system cycle. The other is a clock-enable that is shared with the channel input filters. The filter works in one of two modes. In the first mode, a level must appear on three consecutive samples before it is accepted. In the second mode, a saturating up/down counter integrates the samples. The prescaler counts rising edges of the filtered signal. A new divide value is latched only at the terminal count, so a period that is in progress always completes with the divide value it started with.

Top module: `tbp_timebase`

## Requirements
- R1: While reset is asserted, and after reset until the first prescaler terminal count, `tick_o` is 0 and `count_o` is 0.
- R2: With `src_sel_i` = 2'b00, every rising edge of the filtered external pin advances the prescaler by one step. The pin passes through a two-flop synchronizer first. With a clean square wave of period T cycles, ticks are spaced T*(P+1) cycles apart.
- R3: With `src_sel_i` = 2'b10, the prescaler steps on every second system cycle, so ticks are spaced 2*(P+1) cycles apart.
- R4: With `src_sel_i` = 2'b01 or 2'b11, no tick is produced and `count_o` holds, whatever the pin or the divide field does.
- R5: The divide factor is `div_i` + 1. A value of 0 gives a tick on every source step, and a value of 255 gives a tick on every 256th step.
- R6: A change of `div_i` takes effect at the next terminal count. The period in progress completes with the old factor.
- R7: `tick_o` is never high on two adjacent cycles. `count_o` advances by exactly one, modulo 2^CNT_W, in each cycle in which `tick_o` is high, and holds otherwise.
- R8: Filter sample select is `flt_cfg_i[0]`. When it is 0, the filter samples on every second system cycle. When it is 1, the filter samples only in cycles where `chan_flt_en_i` is high, and with that enable low the filter output is frozen.
- R9: When `flt_cfg_i[1]` = 0, the filtered output takes a new level only after three consecutive samples at that level. A pulse that spans two samples or fewer is removed.
- R10: When `flt_cfg_i[1]` = 1, a 2-bit counter saturates at 0 and 3. It goes up on a high sample and down on a low sample. The filtered output goes to 1 when the counter reaches 3 and goes to 0 when it reaches 0. Otherwise the output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | Asynchronous external clock pin |
| chan_flt_en_i | input | 1 | Channel-filter sample clock-enable |
| src_sel_i | input | 2 | Prescaler source: 00 pin, 10 system/2, 01 and 11 hold |
| div_i | input | DIV_W | Divide field; factor is value + 1 |
| flt_cfg_i | input | 2 | Bit 0: sample clock select; bit 1: integration mode |
| tick_o | output | 1 | One-cycle timebase count-enable |
| count_o | output | CNT_W | Free-running timebase counter |

## Verification
The bench keeps the default 8-bit divide field. This keeps the 256 boundary in reach: on the half-rate source its interval is 512 cycles, which is well inside the run. The counter width is reduced to 4 bits, so `count_o` wraps several times and the modulo advance can be observed. The default 2-bit integrator and the two-sample history give thresholds of three samples. Pulses of two, three, four and ten cycles therefore fall on either side of each filter's limit. The three-cycle high-high-low pattern separates the two filter modes.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [1:0] {
    SRC_PIN  = 2'b00,
    SRC_RSV1 = 2'b01,
    SRC_SYS2 = 2'b10,
    SRC_RSV3 = 2'b11
  } src_e;
endpackage

// File: rtl/tbp_sync.sv
module tbp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tbp_filter.sv
module tbp_filter #(
  parameter int TS_DEPTH = 2,
  parameter int INT_W    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_en_i,
  input  logic integ_i,
  input  logic din_i,
  output logic dout_o
);
  localparam logic [INT_W-1:0] IMAX = '1;

  logic [TS_DEPTH-1:0] hist_q;
  logic                ts_q, int_q;
  logic [INT_W-1:0]    ic_q, ic_nxt;
  logic                all_hi, all_lo;

  // two-sample: current sample plus history must agree
  assign all_hi = din_i & (&hist_q);
  assign all_lo = ~din_i & ~(|hist_q);

  always_comb begin
    ic_nxt = ic_q;
    if (din_i && ic_q != IMAX)       ic_nxt = ic_q + INT_W'(1);
    else if (!din_i && ic_q != '0)   ic_nxt = ic_q - INT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      ts_q   <= 1'b0;
      ic_q   <= '0;
      int_q  <= 1'b0;
    end else if (smp_en_i) begin
      hist_q <= {hist_q[TS_DEPTH-2:0], din_i};
      if (all_hi)      ts_q <= 1'b1;
      else if (all_lo) ts_q <= 1'b0;
      ic_q <= ic_nxt;
      if (ic_nxt == IMAX)    int_q <= 1'b1;
      else if (ic_nxt == '0) int_q <= 1'b0;
    end
  end

  assign dout_o = integ_i ? int_q : ts_q;
endmodule

// File: rtl/tbp_prescale.sv
module tbp_prescale #(
  parameter int DIV_W = 8,
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] count_o
);
  logic [DIV_W-1:0] pc_q, div_q;
  logic             tick_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      div_q  <= '0;
      tick_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      tick_q <= 1'b0;
      if (en_i) begin
        if (pc_q == div_q) begin
          pc_q   <= '0;
          div_q  <= div_i;  // new factor only at terminal count
          tick_q <= 1'b1;
          cnt_q  <= cnt_q + CNT_W'(1);
        end else begin
          pc_q <= pc_q + DIV_W'(1);
        end
      end
    end
  end

  assign tick_o  = tick_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/tbp_timebase.sv
module tbp_timebase
  import tbp_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 24,
  parameter int SYNC_W   = 2,
  parameter int TS_DEPTH = 2,
  parameter int INT_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             chan_flt_en_i,
  input  logic [1:0]       src_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [1:0]       flt_cfg_i,
  output logic             tick_o,
  output logic [CNT_W-1:0] count_o
);
  logic half_q, pin_s, pin_f, pin_f_q, smp_en, pin_rise, src_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q  <= 1'b0;
      pin_f_q <= 1'b0;
    end else begin
      half_q  <= ~half_q;
      pin_f_q <= pin_f;
    end
  end

  tbp_sync #(.STAGES(SYNC_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_clk_i),
    .q_o    (pin_s)
  );

  assign smp_en = flt_cfg_i[0] ? chan_flt_en_i : half_q;

  tbp_filter #(.TS_DEPTH(TS_DEPTH), .INT_W(INT_W)) u_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_en_i (smp_en),
    .integ_i  (flt_cfg_i[1]),
    .din_i    (pin_s),
    .dout_o   (pin_f)
  );

  assign pin_rise = pin_f & ~pin_f_q;

  always_comb begin
    unique case (src_e'(src_sel_i))
      SRC_PIN:  src_en = pin_rise;
      SRC_SYS2: src_en = half_q;
      default:  src_en = 1'b0;
    endcase
  end

  tbp_prescale #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (src_en),
    .div_i   (div_i),
    .tick_o  (tick_o),
    .count_o (count_o)
  );
endmodule

// File: rtl/tbp_timebase_chk.sv
module tbp_timebase_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       src_sel_i,
  input logic             tick_o,
  input logic [CNT_W-1:0] count_o
);
  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R7

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> count_o == $past(count_o) + CNT_W'(1)); // R7

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(count_o)); // R7

  AST_RSVD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(src_sel_i[0]) |-> !tick_o); // R4

  always_comb begin
    if (!rst_ni) begin
      AST_RST_QUIET: assert (!tick_o && count_o == '0); // R1
    end
  end
endmodule

bind tbp_timebase tbp_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_sel_i (src_sel_i),
  .tick_o    (tick_o),
  .count_o   (count_o)
);

// File: tb/test_tbp_timebase.sv
module test_tbp_timebase;
  localparam int DIV_W = 8;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0, ext_clk_i = 1'b0, chan_flt_en_i = 1'b1;
  logic [1:0] src_sel_i = 2'b11, flt_cfg_i = 2'b01;
  logic [DIV_W-1:0] div_i = '0;
  logic tick_o;
  logic [CNT_W-1:0] count_o;

  int n_chk = 0, n_err = 0, ntick = 0, cyc = 0, last_t = 0, ivl = 0, dbl = 0;
  logic prev_tick = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tbp_timebase #(.DIV_W(DIV_W), .CNT_W(CNT_W)) i_tbp_timebase (
    .clk_i(clk), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i), .chan_flt_en_i(chan_flt_en_i),
    .src_sel_i(src_sel_i), .div_i(div_i), .flt_cfg_i(flt_cfg_i),
    .tick_o(tick_o), .count_o(count_o)
  );

  function automatic int exp_sys(int p); return 2 * (p + 1); endfunction
  function automatic int exp_pin(int p, int h); return 2 * h * (p + 1); endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      if (tick_o) begin
        ntick++;
        ivl = cyc - last_t;
        last_t = cyc;
        if (prev_tick) dbl++;
      end
      prev_tick = tick_o;
    end
  endtask

  task automatic wait_tick(output int t);
    int lim = 2000;
    do begin step(); lim--; end while (!tick_o && lim > 0);
    if (lim == 0) chk(1'b0, "R3 tick timeout", 0, 1);
    t = cyc;
  endtask

  // load p into the prescaler and align it at terminal count
  task automatic prep(int p);
    int t;
    src_sel_i = 2'b10; div_i = DIV_W'(p);
    wait_tick(t); wait_tick(t);
  endtask

  task automatic pulse(int w);
    ext_clk_i = 1'b1; step(w); ext_clk_i = 1'b0; step(12);
  endtask

  task automatic glitch(logic [1:0] cfg, int w, int exp, string req);
    int n0;
    prep(0);
    flt_cfg_i = cfg; ext_clk_i = 1'b0; src_sel_i = 2'b00; step(14);
    n0 = ntick;
    pulse(w);
    chk(ntick - n0 == exp, req, ntick - n0, exp);
  endtask

  task automatic hhl(logic [1:0] cfg, int exp, string req);
    int n0;
    prep(0);
    flt_cfg_i = cfg; ext_clk_i = 1'b0; src_sel_i = 2'b00; step(14);
    n0 = ntick;
    repeat (6) begin ext_clk_i = 1'b1; step(2); ext_clk_i = 1'b0; step(1); end
    step(14);
    chk(ntick - n0 == exp, req, ntick - n0, exp);
  endtask

  task automatic sys_run(int p);
    int t1, t2;
    prep(p);
    wait_tick(t1); wait_tick(t2);
    chk(t2 - t1 == exp_sys(p), "R3/R5 system/2 interval", t2 - t1, exp_sys(p));
  endtask

  task automatic pin_run(int p, int h, logic integ);
    int n0;
    prep(p);
    flt_cfg_i = {integ, 1'b1}; chan_flt_en_i = 1'b1; src_sel_i = 2'b00;
    ext_clk_i = 1'b0; step(8);
    n0 = ntick;
    repeat (3 * (p + 1) + 2) begin ext_clk_i = 1'b1; step(h); ext_clk_i = 1'b0; step(h); end
    chk(ntick - n0 >= 2, "R2 pin ticks seen", ntick - n0, 3);
    chk(ivl == exp_pin(p, h), "R2 pin interval", ivl, exp_pin(p, h));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int t0, t1, t2, n0;
    logic [CNT_W-1:0] c0;
    void'($urandom(32'h1d5e));

    step(3);
    chk(tick_o == 1'b0, "R1 tick in reset", int'(tick_o), 0);
    chk(count_o == '0, "R1 count in reset", int'(count_o), 0);
    rst_ni = 1'b1;
    step(5);
    chk(tick_o == 1'b0 && count_o == '0, "R1 idle after reset", int'(count_o), 0);

    // R5 boundaries and R3 random factors
    sys_run(0);
    sys_run(255);
    repeat (6) sys_run($urandom_range(0, 255));

    // R6 divide change lands at terminal count
    prep(3);
    wait_tick(t0);
    div_i = DIV_W'(9);
    wait_tick(t1); wait_tick(t2);
    chk(t1 - t0 == exp_sys(3), "R6 old factor finishes", t1 - t0, exp_sys(3));
    chk(t2 - t1 == exp_sys(9), "R6 new factor applies", t2 - t1, exp_sys(9));

    // R7 count follows ticks and wraps
    prep(0);
    n0 = ntick; c0 = count_o;
    step(80);
    chk(ntick - n0 >= 16, "R7 wrap reached", ntick - n0, 40);
    chk(count_o == CNT_W'(c0 + CNT_W'(ntick - n0)), "R7 count advance", int'(count_o),
        int'(CNT_W'(c0 + CNT_W'(ntick - n0))));

    // R4 reserved sources hold
    for (int s = 1; s < 4; s += 2) begin
      prep(0);
      src_sel_i = 2'(s); step(1);
      n0 = ntick; c0 = count_o;
      repeat (10) begin ext_clk_i = 1'b1; step(4); ext_clk_i = 1'b0; step(4); end
      chk(ntick == n0, "R4 reserved no tick", ntick - n0, 0);
      chk(count_o == c0, "R4 reserved count holds", int'(count_o), int'(c0));
    end

    // R2 pin source, random factor, width and filter mode
    pin_run(0, 3, 1'b0);
    repeat (4) pin_run($urandom_range(0, 5), $urandom_range(3, 6), 1'($urandom_range(0, 1)));

    // R9 two-sample limits, per-cycle sampling
    glitch(2'b01, 2, 0, "R9 two-sample drop");
    glitch(2'b01, 3, 1, "R9 three-sample pass");
    // R8 half-rate sampling and frozen channel enable
    glitch(2'b00, 4, 0, "R8 half-rate drop");
    glitch(2'b00, 10, 1, "R8 half-rate pass");
    chan_flt_en_i = 1'b0;
    glitch(2'b01, 20, 0, "R8 channel enable frozen");
    chan_flt_en_i = 1'b1;

    // R10 integration vs two-sample
    hhl(2'b01, 0, "R9 HHL rejected");
    hhl(2'b11, 1, "R10 HHL integrates");
    glitch(2'b11, 2, 0, "R10 short pulse");
    glitch(2'b11, 3, 1, "R10 saturating pulse");

    chk(dbl == 0, "R7 single-cycle tick", dbl, 0);
    summary();
    $finish;
  end
endmodule